// File: doc/BRIEF.md
# Coloured Branch Address Arbiter

This block picks the next instruction fetch address for a pipelined core whose stages can each raise a control transfer. Normally it forwards the program counter's address to instruction memory. When a pipeline stage needs to change the flow of control, it sends a redirect address instead. The arbiter keeps the master copy of a colour vector that has one bit per stage, and it tags every address it issues with that vector. The fetched instruction carries the tag down the pipe, so each stage can tell a new instruction stream from instructions that were prefetched before a hazard.

A stage that raises a redirect toggles its own bit in the colour it last saw and sends the result with the target address. A deeper stage outranks every shallower one. A redirect is therefore stale if any deeper bit of its vector disagrees with the master copy. A stale redirect is acknowledged and dropped. A fresh one replaces the master vector and its target is issued. All three interfaces use valid/ready handshakes, and the memory side has one registered output slot.

Top module: `hazard_fetch_arbiter`

## Requirements
- R1: After reset `mem_valid_o` is low. The colour vector is all zeros, so the first fetch issued afterwards carries colour 0.
- R2: When no redirect is valid and the output slot is free, `pc_ready_o` is high. A program counter request taken at an edge appears on `mem_addr_o` with `mem_valid_o` high after that edge, tagged with the current colour vector.
- R3: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_addr_o` and `mem_colour_o` hold their values and `pc_ready_o` is low.
- R4: A redirect from stage k (address in `rd_addr_i[k*ADDR_W +: ADDR_W]`, colour in `rd_colour_i[k*NUM_STAGES +: NUM_STAGES]`, where bit i belongs to stage i and a higher i is deeper) is accepted when all of its colour bits above k equal the master copy. Its address is issued after the edge, tagged with its own colour vector, and that vector becomes the master copy.
- R5: A redirect that fails the R4 test is stale. It is acknowledged in the same cycle even when the output slot is full, nothing is issued for it, and the master colour vector does not change.
- R6: When several redirects are valid in one cycle, only the deepest is evaluated. If it is accepted, every valid redirect is acknowledged in that cycle and the shallower ones are dropped without being issued.
- R7: `pc_ready_o` is low in any cycle in which a redirect is valid.
- R8: A redirect that would be accepted keeps its ready low while the output slot is full and not being drained. It is taken in the first cycle in which the slot frees.
- R9: Colour bits of stage k and of shallower stages are not compared for a stage-k redirect. A request that differs from the master copy only in those bits is accepted.
- R10: Program counter fetches issued after an accepted redirect carry the updated colour vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_valid_i | input | 1 | Program counter address valid |
| pc_ready_o | output | 1 | Program counter address taken |
| pc_addr_i | input | ADDR_W | Sequential fetch address |
| rd_valid_i | input | NUM_STAGES | Redirect valid, one bit per stage |
| rd_ready_o | output | NUM_STAGES | Redirect acknowledged, one bit per stage |
| rd_addr_i | input | NUM_STAGES*ADDR_W | Redirect targets, stage k in slice k |
| rd_colour_i | input | NUM_STAGES*NUM_STAGES | Redirect colour vectors, stage k in slice k |
| mem_valid_o | output | 1 | Fetch address valid to memory |
| mem_ready_i | input | 1 | Memory takes the fetch address |
| mem_addr_o | output | ADDR_W | Fetch address |
| mem_colour_o | output | NUM_STAGES | Colour vector tagging the fetch |

## Verification
The bench sends a stale redirect whose deeper bit is out of date. A design that compared the wrong bit range would issue that redirect or change the master colour. The bench also drives two simultaneous redirects. A design that served the shallower one, or served both, would issue the wrong target or issue a second address in the following cycle. A request that differs only in its own and shallower bits must be accepted, which catches an inclusive comparison mask. Back-pressure cases show whether a stale redirect is wrongly stalled, a fresh one is taken while the slot is full, or the pending output is overwritten.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
  localparam int DEF_STAGES = 4;
  localparam int DEF_ADDR_W = 32;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PC    = 2'd1,
    SRC_REDIR = 2'd2
  } src_e;
endpackage

// File: rtl/hfa_prio_pick.sv
module hfa_prio_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // highest index wins: deeper stage
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  // chosen lane is valid and nothing deeper is valid
  p_deepest_pick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((req_i >> idx_o) == N'(1)));
endmodule

// File: rtl/hfa_stale_check.sv
module hfa_stale_check #(
  parameter int N = 4
) (
  input  logic [N-1:0]   master_i,
  input  logic [N*N-1:0] colour_i,
  output logic [N-1:0]   fresh_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    // only bits deeper than k take part
    localparam logic [N-1:0] DEEPER = {N{1'b1}} << (k + 1);
    assign fresh_o[k] = ((colour_i[k*N +: N] ^ master_i) & DEEPER) == '0;
  end
endmodule

// File: rtl/hfa_out_slot.sv
module hfa_out_slot #(
  parameter int N      = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      colour_i,
  output logic              free_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [N-1:0]      colour_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      colour_o <= '0;
    end else if (free_o) begin
      valid_o <= load_i;
      if (load_i) begin
        addr_o   <= addr_i;
        colour_o <= colour_i;
      end
    end
  end

  p_hold_stalled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(colour_o)));
endmodule

// File: rtl/hazard_fetch_arbiter.sv
module hazard_fetch_arbiter
  import hfa_pkg::*;
#(
  parameter int NUM_STAGES = DEF_STAGES,
  parameter int ADDR_W     = DEF_ADDR_W,
  localparam int IW        = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           pc_valid_i,
  output logic                           pc_ready_o,
  input  logic [ADDR_W-1:0]              pc_addr_i,
  input  logic [NUM_STAGES-1:0]          rd_valid_i,
  output logic [NUM_STAGES-1:0]          rd_ready_o,
  input  logic [NUM_STAGES*ADDR_W-1:0]   rd_addr_i,
  input  logic [NUM_STAGES*NUM_STAGES-1:0] rd_colour_i,
  output logic                           mem_valid_o,
  input  logic                           mem_ready_i,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic [NUM_STAGES-1:0]          mem_colour_o
);
  localparam int N = NUM_STAGES;

  logic [N-1:0]      colour_q;
  logic [N-1:0]      fresh;
  logic              rd_any, win_fresh, out_free;
  logic              accept, reject, pc_fire;
  logic [IW-1:0]     win;
  logic [ADDR_W-1:0] ld_addr;
  logic [N-1:0]      ld_colour;
  src_e              src;

  hfa_prio_pick #(.N(N)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (rd_valid_i),
    .any_o (rd_any),
    .idx_o (win)
  );

  hfa_stale_check #(.N(N)) u_check (
    .master_i(colour_q),
    .colour_i(rd_colour_i),
    .fresh_o (fresh)
  );

  assign win_fresh = fresh[win];
  assign accept    = rd_any && win_fresh && out_free;
  assign reject    = rd_any && !win_fresh;   // acked without waiting
  assign pc_ready_o = out_free && !rd_any;
  assign pc_fire   = pc_valid_i && pc_ready_o;

  for (genvar i = 0; i < N; i++) begin : g_ack
    assign rd_ready_o[i] = rd_valid_i[i] &&
                           (((IW'(i) == win) && (accept || reject)) ||
                            ((IW'(i) <  win) && accept));
  end

  always_comb begin
    src = SRC_NONE;
    if (accept)       src = SRC_REDIR;
    else if (pc_fire) src = SRC_PC;
  end

  always_comb begin
    ld_addr   = pc_addr_i;
    ld_colour = colour_q;
    if (src == SRC_REDIR) begin
      ld_addr   = rd_addr_i[win*ADDR_W +: ADDR_W];
      ld_colour = rd_colour_i[win*N +: N];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     colour_q <= '0;
    else if (accept) colour_q <= rd_colour_i[win*N +: N];
  end

  hfa_out_slot #(.N(N), .ADDR_W(ADDR_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (src != SRC_NONE),
    .addr_i  (ld_addr),
    .colour_i(ld_colour),
    .free_o  (out_free),
    .valid_o (mem_valid_o),
    .ready_i (mem_ready_i),
    .addr_o  (mem_addr_o),
    .colour_o(mem_colour_o)
  );

  p_pc_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any |-> !pc_ready_o);

  p_stale_acked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |-> (rd_ready_o[win] && (rd_ready_o & ~rd_valid_i) == '0));

  p_stale_keeps_colour_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> $stable(colour_q));

  p_accept_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (mem_valid_o && mem_colour_o == colour_q));

  p_pc_tag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_fire |=> (mem_valid_o && mem_colour_o == colour_q));
endmodule

// File: tb/hazard_fetch_arbiter_test.sv
`timescale 1ns/1ps
module hazard_fetch_arbiter_test;
  localparam int N  = 4;
  localparam int AW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pc_valid = 1'b0;
  logic              pc_ready;
  logic [AW-1:0]     pc_addr = '0;
  logic [N-1:0]      rd_valid = '0;
  logic [N-1:0]      rd_ready;
  logic [N*AW-1:0]   rd_addr = '0;
  logic [N*N-1:0]    rd_colour = '0;
  logic              mem_valid;
  logic              mem_ready = 1'b1;
  logic [AW-1:0]     mem_addr;
  logic [N-1:0]      mem_colour;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hazard_fetch_arbiter #(.NUM_STAGES(N), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_valid_i(pc_valid), .pc_ready_o(pc_ready), .pc_addr_i(pc_addr),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready),
    .rd_addr_i(rd_addr), .rd_colour_i(rd_colour),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_colour_o(mem_colour)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_rd(int k, logic [AW-1:0] a, logic [N-1:0] c);
    rd_valid[k] = 1'b1;
    rd_addr[k*AW +: AW] = a;
    rd_colour[k*N +: N] = c;
  endtask

  task automatic clear_in();
    pc_valid = 1'b0;
    rd_valid = '0;
  endtask

  // program counter fetch with the slot draining
  task automatic pc_fetch(logic [AW-1:0] a, logic [N-1:0] exp_c, string req);
    @(negedge clk);
    pc_valid = 1'b1; pc_addr = a;
    #1 check({req, " pc_ready"}, pc_ready, 1);
    @(negedge clk);
    clear_in();
    check({req, " valid"}, mem_valid, 1);
    check({req, " addr"}, mem_addr, a);
    check({req, " colour"}, mem_colour, exp_c);
  endtask

  task automatic t_reset();
    check("R1 mem_valid after reset", mem_valid, 0);
    check("R1 rd_ready idle", rd_ready, 0);
    pc_fetch(32'h100, 4'b0000, "R1 first fetch tag");
    pc_fetch(32'h104, 4'b0000, "R2 pc fetch");
  endtask

  task automatic t_accept();
    @(negedge clk);
    set_rd(1, 32'h2000, 4'b0010);
    pc_valid = 1'b1; pc_addr = 32'h108;
    #1 check("R4 stage1 acked", rd_ready, 4'b0010);
    check("R7 pc held", pc_ready, 0);
    @(negedge clk);
    clear_in();
    check("R4 redirect addr", mem_addr, 32'h2000);
    check("R4 redirect colour", mem_colour, 4'b0010);
    pc_fetch(32'h2004, 4'b0010, "R10 new colour on pc");
  endtask

  task automatic t_stale();
    @(negedge clk);
    set_rd(0, 32'h3000, 4'b0001);   // bit1 old: stale
    #1 check("R5 stale acked", rd_ready, 4'b0001);
    @(negedge clk);
    clear_in();
    check("R5 stale not issued", mem_valid, 0);
    pc_fetch(32'h2008, 4'b0010, "R5 colour unchanged");
  endtask

  task automatic t_own_bits();
    @(negedge clk);
    set_rd(2, 32'h4000, 4'b0101);   // bits 0..2 differ, bit3 matches
    #1 check("R9 accepted despite low bits", rd_ready, 4'b0100);
    @(negedge clk);
    clear_in();
    check("R9 addr", mem_addr, 32'h4000);
    check("R9 colour", mem_colour, 4'b0101);
  endtask

  task automatic t_multi();
    @(negedge clk);
    set_rd(3, 32'h5000, 4'b1101);
    set_rd(1, 32'h6000, 4'b0111);
    pc_valid = 1'b1; pc_addr = 32'h4004;
    #1 check("R6 all acked", rd_ready, 4'b1010);
    check("R7 pc held multi", pc_ready, 0);
    @(negedge clk);
    clear_in();
    check("R6 deepest addr", mem_addr, 32'h5000);
    check("R6 deepest colour", mem_colour, 4'b1101);
    @(negedge clk);
    check("R6 shallower dropped", mem_valid, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    mem_ready = 1'b0;
    pc_valid = 1'b1; pc_addr = 32'h5004;
    @(negedge clk);
    pc_addr = 32'h5008;
    #1 check("R3 pc_ready low when full", pc_ready, 0);
    @(negedge clk);
    pc_valid = 1'b0;
    check("R3 held valid", mem_valid, 1);
    check("R3 held addr", mem_addr, 32'h5004);
    check("R3 held colour", mem_colour, 4'b1101);
    set_rd(2, 32'h7000, 4'b0001);   // bit3 old: stale
    #1 check("R5 stale acked while full", rd_ready, 4'b0100);
    @(negedge clk);
    clear_in();
    set_rd(3, 32'h8000, 4'b0101);
    #1 check("R8 fresh waits while full", rd_ready, 0);
    @(negedge clk);
    check("R8 slot still pending", mem_addr, 32'h5004);
    mem_ready = 1'b1;
    #1 check("R8 taken when slot frees", rd_ready, 4'b1000);
    @(negedge clk);
    clear_in();
    check("R8 addr", mem_addr, 32'h8000);
    check("R8 colour", mem_colour, 4'b0101);
    pc_fetch(32'h8004, 4'b0101, "R10 colour after stall");
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept();
    t_stale();
    t_own_bits();
    t_multi();
    t_backpressure();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule